// File: doc/BRIEF.md
# Match-Capture Timer with PWM Outputs

This block is a general timer for a peripheral subsystem. A prescaler divides the peripheral clock by a programmable amount and every prescaler rollover advances a timer count. Up to four compare channels watch the count continuously. When a channel's value is reached, it can flag an interrupt, restart the count at zero, or halt the timer. Each channel also owns an output pin. In normal mode the pin changes by a two-bit action code on every hit. In PWM mode the pin is high once the count has reached the channel value.

A single capture input is brought into the clock domain through a two-stage synchroniser. Selected edges on it copy the count into a capture register, can raise an interrupt, and can zero both the count and the prescaler. In counter mode the prescaler is idle and the selected edges of the same input advance the count instead. Software uses a flat register port with a single-cycle write strobe and a combinational read. A single interrupt line is the OR of the sticky status flags, and writing a 1 to a status bit clears it.

Top module: `mcap_timer`

## Requirements
- R1: After reset the count (address 2), the prescale count (address 3), the capture value (address 10), the control register (address 0), the status register (address 13), `irq` and every `match_out` bit are all zero.
- R2: The control register holds run in bit 0. While run is 1 and counter mode is off, the prescale count steps by one each clock and returns to 0 on the clock after it equals the prescale limit (address 1). That return advances the count by one, so after K clocks from run the count is floor(K/(limit+1)).
- R3: The count wraps from its all-ones value to 0, and the wrap sets no status flag.
- R4: Compare values sit at addresses 4 to 7, one per channel. The channel actions at address 8 take bits 3i to 3i+2 for channel i: interrupt, reset and stop. When the count takes a channel's value on an advance, status bit i is set on the following clock, but only if the interrupt action bit is 1.
- R5: With the reset action, the advance that would leave the channel value loads 0 instead, so one cycle lasts value+1 advances.
- R6: With the stop action, a hit clears run in the same clock and the count stays at the channel value.
- R7: The pin control at address 11 holds the pin levels in bits 0 to 3 and channel i's code in bits 4+2i and 5+2i. On a hit, code 00 keeps the pin, 01 drives it low, 10 drives it high and 11 inverts it.
- R8: The capture control at address 9 takes bit 0 for rising edges, bit 1 for falling edges, bit 2 for interrupt and bit 3 for clear. A selected edge copies the count into the capture value and, with bit 2 set, sets status bit 4. Edges that are not selected change neither.
- R9: With capture bit 3 set, a capture zeroes both the count and the prescale count in the same clock.
- R10: Bit i at address 12 puts channel i in PWM mode. Its pin is low while the count is below the channel value and high from that value on. When the value equals the reset-action cycle end, the result is a one-advance-wide high pulse in every cycle.
- R11: Control bit 2 selects counter mode. Bits 4:3 pick the counting edges of the synchronised capture input: 01 rising, 10 falling, 11 both. In this mode the prescale count does not move and no capture takes place.
- R12: Status bits are sticky. Writing 1 to a bit clears it, writing 0 leaves it, and `irq` is high while any status bit is set.
- R13: Control bit 1 holds the count and the prescale count at 0 while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Combinational read data |
| cap_in | input | 1 | Capture / count input, asynchronous |
| match_out | output | N_MATCH | Per-channel match or PWM output |
| irq | output | 1 | Interrupt, OR of status flags |

## Verification
On every cycle, the bound checker enforces the following. The count only ever steps by one or returns to zero. The hold bit zeroes both counters. A stop hit clears run and freezes the count. A capture copies the count of the previous clock. Status flags fall only on a status write. Counter mode freezes the prescaler. A PWM pin stays low below its compare value. The bench scenarios show what needs known stimulus and timing: the prescale division ratios, the clock on which a flag rises after a hit, the gating of flags by the interrupt action, each pin action code, the exact captured value behind the synchroniser, the one-advance PWM pulse at the cycle end, the edge counting for each selection, and the silent wrap.

// File: rtl/mct_pkg.sv
package mct_pkg;
   localparam int BUS_W  = 32;
   localparam int REG_AW = 4;

   localparam logic [REG_AW-1:0] A_CTRL = 4'd0;
   localparam logic [REG_AW-1:0] A_PRE  = 4'd1;
   localparam logic [REG_AW-1:0] A_TC   = 4'd2;
   localparam logic [REG_AW-1:0] A_PC   = 4'd3;
   localparam logic [REG_AW-1:0] A_MR0  = 4'd4;
   localparam logic [REG_AW-1:0] A_MACT = 4'd8;
   localparam logic [REG_AW-1:0] A_CAPC = 4'd9;
   localparam logic [REG_AW-1:0] A_CAPV = 4'd10;
   localparam logic [REG_AW-1:0] A_EXT  = 4'd11;
   localparam logic [REG_AW-1:0] A_PWM  = 4'd12;
   localparam logic [REG_AW-1:0] A_STAT = 4'd13;

   localparam int STAT_W   = 5;
   localparam int CAP_FLAG = 4;
   localparam int EXT_CODE_LSB = 4;

   typedef enum logic [1:0] {
      EXT_KEEP = 2'b00,
      EXT_LOW  = 2'b01,
      EXT_HIGH = 2'b10,
      EXT_FLIP = 2'b11
   } ext_act_e;

   typedef struct packed {
      logic stop;
      logic rst;
      logic irq;
   } match_act_t;

   typedef struct packed {
      logic clr;
      logic irq;
      logic fall;
      logic rise;
   } cap_cfg_t;

   function automatic logic ext_apply(input logic cur, input logic [1:0] code);
      logic nxt;
      case (ext_act_e'(code))
         EXT_KEEP: nxt = cur;
         EXT_LOW:  nxt = 1'b0;
         EXT_HIGH: nxt = 1'b1;
         EXT_FLIP: nxt = ~cur;
         default:  nxt = cur;
      endcase
      return nxt;
   endfunction
endpackage

// File: rtl/mct_prescale.sv
module mct_prescale #(
   parameter int PRE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic             clr,
   input  logic             cmode,
   input  logic             cnt_edge,
   input  logic [PRE_W-1:0] limit,
   output logic             tick,
   output logic [PRE_W-1:0] pc
);
   logic wrap;

   // >= keeps the counter bounded if the limit is lowered mid-count
   assign wrap = (pc >= limit);
   assign tick = run & ~hold & ~clr & (cmode ? cnt_edge : wrap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc <= '0;
      else if (hold || clr)
         pc <= '0;
      else if (run && !cmode)
         pc <= wrap ? '0 : pc + 1'b1;
   end
endmodule

// File: rtl/mct_capture.sv
module mct_capture
   import mct_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin,
   input  cap_cfg_t         cfg,
   input  logic             cmode,
   input  logic [CNT_W-1:0] tc,
   output logic             rise,
   output logic             fall,
   output logic             cap_ev,
   output logic [CNT_W-1:0] cap_val
);
   logic s0, s1, s2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s0 <= 1'b0;
         s1 <= 1'b0;
         s2 <= 1'b0;
      end else begin
         s0 <= pin;
         s1 <= s0;
         s2 <= s1;
      end
   end

   assign rise   = s1 & ~s2;
   assign fall   = ~s1 & s2;
   assign cap_ev = ~cmode & ((rise & cfg.rise) | (fall & cfg.fall));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cap_val <= '0;
      else if (cap_ev)
         cap_val <= tc;
   end
endmodule

// File: rtl/mct_match.sv
module mct_match #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] tc,
   input  logic [CNT_W-1:0] mr,
   input  logic             upd,
   input  logic             pwm_mode,
   input  logic             ext_lvl,
   output logic             eq,
   output logic             ev,
   output logic             pin
);
   assign eq  = (tc == mr);
   // a hit is the first cycle the count holds the value after an advance
   assign ev  = upd & eq;
   assign pin = pwm_mode ? (tc >= mr) : ext_lvl;
endmodule

// File: rtl/mcap_timer.sv
module mcap_timer
   import mct_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int PRE_W   = 16,
   parameter int N_MATCH = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [3:0]         wr_addr,
   input  logic [31:0]        wr_data,
   input  logic [3:0]         rd_addr,
   output logic [31:0]        rd_data,
   input  logic               cap_in,
   output logic [N_MATCH-1:0] match_out,
   output logic               irq
);
   localparam int ACT_W = 3;

   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt_w
      $error("mcap_timer: CNT_W out of range");
   end
   if (PRE_W < 1 || PRE_W > BUS_W) begin : g_bad_pre_w
      $error("mcap_timer: PRE_W out of range");
   end
   if (N_MATCH < 1 || N_MATCH > 4) begin : g_bad_n_match
      $error("mcap_timer: N_MATCH must be 1 to 4");
   end

   logic               en, hold, cmode;
   logic [1:0]         cedge;
   logic [PRE_W-1:0]   pre;
   logic [CNT_W-1:0]   mr [N_MATCH];
   match_act_t         mact [N_MATCH];
   cap_cfg_t           capc;
   logic [N_MATCH-1:0] ext_lvl;
   logic [1:0]         ext_code [N_MATCH];
   logic [N_MATCH-1:0] pwm_en;
   logic [STAT_W-1:0]  stat;
   logic [CNT_W-1:0]   tc;
   logic               upd_q;

   logic [PRE_W-1:0]   pc;
   logic               tick, rise, fall, cap_ev, cap_clr, cnt_edge;
   logic [CNT_W-1:0]   cap_val;
   logic [N_MATCH-1:0] eq, ev, stop_mask, rst_mask;
   logic               stop_now, rst_hit, run_eff;
   logic [STAT_W-1:0]  set_mask;
   logic               unused_bits;

   assign unused_bits = ^wr_data;

   always_comb begin
      for (int i = 0; i < N_MATCH; i++) begin
         stop_mask[i] = mact[i].stop;
         rst_mask[i]  = mact[i].rst;
      end
   end

   assign stop_now = |(ev & stop_mask);
   assign rst_hit  = |(eq & rst_mask);
   assign run_eff  = en & ~stop_now;
   assign cap_clr  = cap_ev & capc.clr;
   assign cnt_edge = (cedge[0] & rise) | (cedge[1] & fall);

   mct_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_eff), .hold(hold), .clr(cap_clr),
      .cmode(cmode), .cnt_edge(cnt_edge), .limit(pre), .tick(tick), .pc(pc)
   );

   mct_capture #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .pin(cap_in), .cfg(capc), .cmode(cmode),
      .tc(tc), .rise(rise), .fall(fall), .cap_ev(cap_ev), .cap_val(cap_val)
   );

   for (genvar g = 0; g < N_MATCH; g++) begin : g_ch
      mct_match #(.CNT_W(CNT_W)) u_m (
         .tc(tc), .mr(mr[g]), .upd(upd_q), .pwm_mode(pwm_en[g]),
         .ext_lvl(ext_lvl[g]), .eq(eq[g]), .ev(ev[g]), .pin(match_out[g])
      );
   end

   // timer count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc    <= '0;
         upd_q <= 1'b0;
      end else begin
         upd_q <= tick;
         if (hold || cap_clr)
            tc <= '0;
         else if (tick)
            tc <= rst_hit ? '0 : tc + 1'b1;
      end
   end

   // control and configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en    <= 1'b0;
         hold  <= 1'b0;
         cmode <= 1'b0;
         cedge <= '0;
         pre   <= '0;
         capc  <= '0;
         pwm_en <= '0;
         for (int i = 0; i < N_MATCH; i++) begin
            mr[i]   <= '0;
            mact[i] <= '0;
         end
      end else begin
         if (wr_en && wr_addr == A_CTRL) begin
            en    <= wr_data[0];
            hold  <= wr_data[1];
            cmode <= wr_data[2];
            cedge <= wr_data[4:3];
         end
         if (stop_now)
            en <= 1'b0;
         if (wr_en && wr_addr == A_PRE)
            pre <= wr_data[PRE_W-1:0];
         if (wr_en && wr_addr == A_CAPC)
            capc <= cap_cfg_t'(wr_data[3:0]);
         if (wr_en && wr_addr == A_PWM)
            pwm_en <= wr_data[N_MATCH-1:0];
         for (int i = 0; i < N_MATCH; i++) begin
            if (wr_en && wr_addr == A_MR0 + 4'(i))
               mr[i] <= wr_data[CNT_W-1:0];
            if (wr_en && wr_addr == A_MACT)
               mact[i] <= match_act_t'(wr_data[ACT_W*i +: ACT_W]);
         end
      end
   end

   // external match pin state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_lvl <= '0;
         for (int i = 0; i < N_MATCH; i++)
            ext_code[i] <= '0;
      end else begin
         for (int i = 0; i < N_MATCH; i++) begin
            if (wr_en && wr_addr == A_EXT) begin
               ext_lvl[i]  <= wr_data[i];
               ext_code[i] <= wr_data[EXT_CODE_LSB + 2*i +: 2];
            end else if (ev[i]) begin
               ext_lvl[i]  <= ext_apply(ext_lvl[i], ext_code[i]);
            end
         end
      end
   end

   // sticky status, write one to clear, a new set wins
   always_comb begin
      set_mask = '0;
      for (int i = 0; i < N_MATCH; i++)
         set_mask[i] = ev[i] & mact[i].irq;
      set_mask[CAP_FLAG] = cap_ev & capc.irq;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat <= '0;
      else if (wr_en && wr_addr == A_STAT)
         stat <= (stat & ~wr_data[STAT_W-1:0]) | set_mask;
      else
         stat <= stat | set_mask;
   end

   assign irq = |stat;

   // read mux
   always_comb begin
      logic [1:0] idx;
      idx     = 2'(rd_addr - A_MR0);
      rd_data = '0;
      case (rd_addr)
         A_CTRL: rd_data[4:0] = {cedge, cmode, hold, en};
         A_PRE:  rd_data = 32'(pre);
         A_TC:   rd_data = 32'(tc);
         A_PC:   rd_data = 32'(pc);
         A_CAPC: rd_data[3:0] = capc;
         A_CAPV: rd_data = 32'(cap_val);
         A_PWM:  rd_data = 32'(pwm_en);
         A_STAT: rd_data = 32'(stat);
         A_MACT: begin
            for (int i = 0; i < N_MATCH; i++)
               rd_data[ACT_W*i +: ACT_W] = mact[i];
         end
         A_EXT: begin
            for (int i = 0; i < N_MATCH; i++) begin
               rd_data[i] = ext_lvl[i];
               rd_data[EXT_CODE_LSB + 2*i +: 2] = ext_code[i];
            end
         end
         default: begin
            if (rd_addr >= A_MR0 && rd_addr < A_MACT && int'(idx) < N_MATCH)
               rd_data = 32'(mr[idx]);
         end
      endcase
   end
endmodule

// File: rtl/mct_chk.sv
module mct_chk
   import mct_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int PRE_W   = 16,
   parameter int N_MATCH = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [CNT_W-1:0]   tc,
   input logic [PRE_W-1:0]   pc,
   input logic               en,
   input logic               hold,
   input logic               cmode,
   input logic [STAT_W-1:0]  stat,
   input logic               wr_en,
   input logic [3:0]         wr_addr,
   input logic [N_MATCH-1:0] ev,
   input logic [N_MATCH-1:0] stop_mask,
   input logic               cap_ev,
   input logic [CNT_W-1:0]   cap_val,
   input logic               pwm0,
   input logic               pin0,
   input logic [CNT_W-1:0]   mr0
);
   p_tc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tc != $past(tc)) |-> ((tc == CNT_W'($past(tc) + 1'b1)) || (tc == '0)));

   p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> ((tc == '0) && (pc == '0)));

   p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(ev & stop_mask)) && !hold && !cap_ev) |=> (!en && $stable(tc)));

   p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ev |=> (cap_val == $past(tc)));

   p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == A_STAT) |=> (($past(stat) & ~stat) == '0));

   p_cmode_pc_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmode && $past(cmode) && !$past(hold)) |-> $stable(pc));

   p_pwm_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm0 && (tc < mr0)) |-> !pin0);
endmodule

bind mcap_timer mct_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W), .N_MATCH(N_MATCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .tc(tc), .pc(pc), .en(en), .hold(hold),
   .cmode(cmode), .stat(stat), .wr_en(wr_en), .wr_addr(wr_addr), .ev(ev),
   .stop_mask(stop_mask), .cap_ev(cap_ev), .cap_val(cap_val),
   .pwm0(pwm_en[0]), .pin0(match_out[0]), .mr0(mr[0])
);

// File: tb/sim_mcap_timer.sv
module sim_mcap_timer;
   localparam logic [3:0] CTRL = 4'd0, PRE = 4'd1, TC = 4'd2, PC = 4'd3;
   localparam logic [3:0] MR0 = 4'd4, MR1 = 4'd5, MR2 = 4'd6, MR3 = 4'd7;
   localparam logic [3:0] MACT = 4'd8, CAPC = 4'd9, CAPV = 4'd10;
   localparam logic [3:0] EXT = 4'd11, PWM = 4'd12, STAT = 4'd13;

   // prescale limit, clocks after run, expected count
   localparam int unsigned TBL [6][3] = '{
      '{0, 10, 10}, '{1, 10, 5}, '{2, 10, 3},
      '{3, 9, 2},   '{4, 20, 4}, '{0, 1, 1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        cap_in = 1'b0;
   logic [3:0]  match_out;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   mcap_timer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .cap_in(cap_in), .match_out(match_out), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic wt(input int k);
      repeat (k) @(posedge clk);
      #1;
   endtask

   task automatic clean();
      wr(CTRL, 32'h2);
      wr(MACT, 32'h0);
      wr(CAPC, 32'h0);
      wr(PWM, 32'h0);
      wr(EXT, 32'h0);
      wr(STAT, 32'h1F);
   endtask

   task automatic pulse();
      @(negedge clk) cap_in = 1'b1;
      repeat (3) @(negedge clk);
      cap_in = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;

      // R1 reset state
      rd(TC, v);   chk("R1 count", v, 0);
      rd(PC, v);   chk("R1 prescale", v, 0);
      rd(CAPV, v); chk("R1 capture", v, 0);
      rd(CTRL, v); chk("R1 control", v, 0);
      rd(STAT, v); chk("R1 status", v, 0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 pins", 32'(match_out), 0);

      // R2 prescale table
      foreach (TBL[i]) begin
         clean();
         wr(PRE, TBL[i][0]);
         wr(CTRL, 32'h1);
         wt(int'(TBL[i][1]));
         rd(TC, v);
         chk("R2 prescale ratio", v, TBL[i][2]);
      end

      // R4 flag one clock after hit, gated by interrupt action; R12 clear
      clean();
      wr(PRE, 0); wr(MR0, 5); wr(MR1, 3); wr(MACT, 32'h1);
      wr(CTRL, 32'h1);
      wt(5); rd(STAT, v); chk("R4 flag not yet", v, 0);
      wt(1); rd(STAT, v); chk("R4 flag set, ch1 gated", v, 1);
      chk("R12 irq high", 32'(irq), 1);
      wr(STAT, 32'h0); rd(STAT, v); chk("R12 write zero keeps", v, 1);
      wr(STAT, 32'h1); rd(STAT, v); chk("R12 write one clears", v, 0);
      chk("R12 irq low", 32'(irq), 0);

      // R5 reset action, cycle of 4 advances at limit 1
      clean();
      wr(PRE, 1); wr(MR0, 3); wr(MACT, 32'h2);
      wr(CTRL, 32'h1);
      wt(7); rd(TC, v); chk("R5 at value", v, 3);
      wt(1); rd(TC, v); chk("R5 restart", v, 0);
      wt(2); rd(TC, v); chk("R5 next cycle", v, 1);

      // R6 stop action
      clean();
      wr(PRE, 0); wr(MR2, 4); wr(MACT, 32'h4 << 6);
      wr(CTRL, 32'h1);
      wt(10);
      rd(TC, v);   chk("R6 count frozen", v, 4);
      rd(CTRL, v); chk("R6 run cleared", v, 0);

      // R7 pin action codes
      clean();
      wr(PRE, 0); wr(MR0, 2); wr(MR1, 2); wr(MR2, 2); wr(MR3, 2);
      wr(EXT, 32'h399);
      chk("R7 pins loaded", 32'(match_out), 32'h9);
      wr(CTRL, 32'h1);
      wt(2); chk("R7 before hit", 32'(match_out), 32'h9);
      wt(2); chk("R7 keep/low/high/flip", 32'(match_out), 32'hE);

      // R8 capture on rising edge with interrupt
      clean();
      wr(PRE, 0); wr(CAPC, 32'h5);
      wr(CTRL, 32'h1);
      wt(10);
      @(negedge clk) cap_in = 1'b1;
      wt(3);
      rd(CAPV, v); chk("R8 captured count", v, 12);
      rd(STAT, v); chk("R8 capture flag", v, 32'h10);
      wr(STAT, 32'h10);
      @(negedge clk) cap_in = 1'b0;
      wt(6);
      rd(CAPV, v); chk("R8 falling ignored value", v, 12);
      rd(STAT, v); chk("R8 falling ignored flag", v, 0);

      // R9 capture on falling edge clears count and prescaler
      clean();
      wr(PRE, 2); wr(CAPC, 32'hA);
      @(negedge clk) cap_in = 1'b1;
      wt(5);
      wr(CTRL, 32'h1);
      wt(20); rd(TC, v); chk("R2 count at limit 2", v, 6);
      @(negedge clk) cap_in = 1'b0;
      wt(3);
      rd(TC, v);   chk("R9 count cleared", v, 0);
      rd(PC, v);   chk("R9 prescale cleared", v, 0);
      rd(CAPV, v); chk("R9 captured", v, 7);
      wt(1); rd(PC, v); chk("R9 prescale resumes", v, 1);

      // R10 PWM with cycle end at 5 from channel 3
      clean();
      wr(PRE, 0); wr(MR3, 5); wr(MACT, 32'h2 << 9);
      wr(MR0, 2); wr(MR1, 5); wr(PWM, 32'h3);
      wr(CTRL, 32'h1);
      for (int k = 1; k <= 12; k++) begin
         int t;
         logic [31:0] e;
         t = k % 6;
         e = {30'd0, (t == 5), (t >= 2)};
         wt(1);
         chk("R10 pwm pins", 32'(match_out), e);
      end

      // R11 counter mode, rising then both edges
      clean();
      wr(CTRL, 32'h1 | 32'h4 | (32'h1 << 3));
      for (int p = 0; p < 4; p++) pulse();
      wt(4);
      rd(TC, v); chk("R11 rising edges", v, 4);
      rd(PC, v); chk("R11 prescale idle", v, 0);
      wr(CTRL, 32'h2 | 32'h4 | (32'h3 << 3));
      wr(CTRL, 32'h1 | 32'h4 | (32'h3 << 3));
      for (int p = 0; p < 3; p++) pulse();
      wt(4);
      rd(TC, v); chk("R11 both edges", v, 6);

      // R13 hold
      clean();
      wr(PRE, 0); wr(CTRL, 32'h1);
      wt(5); rd(TC, v); chk("R13 counting", v, 5);
      wr(CTRL, 32'h3);
      wt(3);
      rd(TC, v); chk("R13 count held", v, 0);
      rd(PC, v); chk("R13 prescale held", v, 0);

      // R3 silent wrap
      clean();
      wr(PRE, 0); wr(CTRL, 32'h1);
      wt(65535); rd(TC, v); chk("R3 all ones", v, 32'hFFFF);
      wt(1);     rd(TC, v); chk("R3 wrapped", v, 0);
      rd(STAT, v); chk("R3 no flag", v, 0);
      chk("R3 no irq", 32'(irq), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule